// File: doc/BRIEF.md
# Endian-Selectable Byte-Lane Memory Port

This block joins a 32-bit load/store datapath to a byte-addressed memory whose bus is one 32-bit word wide. A request carries a byte address, a direction and a size (whole word or single byte). The block presents the word-aligned address to the memory and drives four per-lane write strobes. For a byte store, the store byte is copied onto every lane and only the addressed lane is enabled. For a byte load, the addressed lane is picked out of the returned word, zero-extended and registered. The mapping of a byte offset to a lane depends on a byte-order mode. The mode is taken from a strap pin only while reset is held and is frozen afterwards.

A small sequential program-address register sits beside the data port. It moves forward by one word (4 bytes) on each advance request. A branch request loads an arbitrary target instead.

Top module: `mem_lane_unit`

## Requirements
- R1: While `rst_n` is low, the byte-order mode is loaded from `strap_big` (1 = big-endian, 0 = little-endian) on every rising clock edge and shown on `big_mode`. Once `rst_n` is high, changes on `strap_big` have no effect on `big_mode`.
- R2: `mem_addr` equals `req_addr` with bits [1:0] forced to zero, for both access sizes.
- R3: A word store (`req_valid`=1, `req_write`=1, `req_byte`=0) drives `mem_we` = 4'b1111 and passes `req_wdata` through to `mem_wdata` unchanged.
- R4: A byte store drives exactly one bit of `mem_we` and puts `req_wdata[7:0]` on all four lanes of `mem_wdata`. Lane k means bits [8k+7:8k] and `mem_we[k]`. For byte offset o = `req_addr[1:0]`, the lane is o in little-endian mode and 3-o in big-endian mode.
- R5: `mem_we` is 4'b0000 whenever there is no valid store.
- R6: A byte load (`req_valid`=1, `req_write`=0, `req_byte`=1) yields, at the next rising edge, `ld_valid`=1 and `ld_data` = the lane chosen as in R4, zero-extended to 32 bits. After a cycle with no load, `ld_valid` is 0.
- R7: A word load yields `ld_data` = `mem_rdata` unchanged at the next edge, in either byte-order mode.
- R8: `align_err` is 1 in the same cycle as a valid word access whose `req_addr[1:0]` is nonzero. The access still proceeds at the aligned address. Byte accesses never raise it.
- R9: `fetch_pc` resets to `RESET_PC` (default 32'h0000_0100). On each edge it takes `fetch_target` if `fetch_branch`=1 (this has priority), else adds 4 modulo 2^32 if `fetch_adv`=1, else holds its value.
- R10: During reset, `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_big | input | 1 | Byte-order strap, sampled only in reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data (byte stores use bits [7:0]) |
| mem_rdata | input | 32 | Word returned by memory in the request cycle |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 4 | Per-lane write strobes |
| mem_wdata | output | 32 | Lane-arranged store data |
| ld_valid | output | 1 | Registered load result valid |
| ld_data | output | 32 | Registered load result |
| align_err | output | 1 | Misaligned word access flag |
| big_mode | output | 1 | Latched byte-order mode |
| fetch_adv | input | 1 | Advance program address by one word |
| fetch_branch | input | 1 | Load program address from target |
| fetch_target | input | 32 | Branch target address |
| fetch_pc | output | 32 | Current program address |

## Verification
The hardest situation to reach from the ports is the second byte-order mode. Byte order can only change through a full reset with the strap driven the other way. The stimulus therefore runs the complete byte store and byte load sweeps twice, once after a reset with the strap low and once after a reset with it high. After each release, the strap is toggled to show that the latched mode stays put. Program-address wraparound is reached by branching to the last word of the address space and then advancing once.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
  typedef enum logic {ENDIAN_LITTLE = 1'b0, ENDIAN_BIG = 1'b1} endian_e;
  localparam int unsigned MLU_BYTE_W = 8;
endpackage

// File: rtl/mlu_mode_latch.sv
module mlu_mode_latch
  import mlu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strap_big,
  output endian_e mode
);
  endian_e mode_q;

  // Loaded only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= strap_big ? ENDIAN_BIG : ENDIAN_LITTLE;
  end

  assign mode = mode_q;
endmodule

// File: rtl/mlu_store_steer.sv
module mlu_store_steer
  import mlu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / MLU_BYTE_W,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  endian_e           mode,
  input  logic              wr_en,
  input  logic              is_byte,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  we,
  output logic [DATA_W-1:0] wdata_out,
  output logic [OFF_W-1:0]  lane_sel
);
  // Byte offset to physical lane under the given byte order.
  function automatic logic [OFF_W-1:0] phys_lane(endian_e m, logic [OFF_W-1:0] off);
    return (m == ENDIAN_BIG) ? (OFF_W'(LANES - 1) - off) : off;
  endfunction

  assign lane_sel = phys_lane(mode, offset);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign we[i] = wr_en & (~is_byte | (lane_sel == OFF_W'(i)));
    assign wdata_out[i*MLU_BYTE_W +: MLU_BYTE_W] =
      is_byte ? wdata[MLU_BYTE_W-1:0] : wdata[i*MLU_BYTE_W +: MLU_BYTE_W];
  end
endmodule

// File: rtl/mlu_load_path.sv
module mlu_load_path
  import mlu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / MLU_BYTE_W,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              is_byte,
  input  logic [OFF_W-1:0]  lane_sel,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  function automatic logic [DATA_W-1:0] pick_lane(logic [DATA_W-1:0] word,
                                                  logic [OFF_W-1:0] lane);
    logic [MLU_BYTE_W-1:0] b;
    b = word[int'(lane)*MLU_BYTE_W +: MLU_BYTE_W];
    return DATA_W'(b);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= rd_en;
      if (rd_en) ld_data <= is_byte ? pick_lane(rdata, lane_sel) : rdata;
    end
  end
endmodule

// File: rtl/mlu_fetch_seq.sv
module mlu_fetch_seq #(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100,
  parameter int unsigned STEP     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              branch,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);
  function automatic logic [ADDR_W-1:0] next_seq(logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(STEP);
  endfunction

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pc_q <= RESET_PC;
    else if (branch) pc_q <= target;
    else if (adv)    pc_q <= next_seq(pc_q);
  end

  assign pc = pc_q;
endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
  import mlu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100,
  localparam int unsigned LANES   = DATA_W / MLU_BYTE_W,
  localparam int unsigned OFF_W   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_big,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              align_err,
  output logic              big_mode,
  input  logic              fetch_adv,
  input  logic              fetch_branch,
  input  logic [ADDR_W-1:0] fetch_target,
  output logic [ADDR_W-1:0] fetch_pc
);
  endian_e          mode;
  logic             wr_evt;
  logic             rd_evt;
  logic [OFF_W-1:0] byte_off;
  logic [OFF_W-1:0] lane_sel;

  assign wr_evt    = req_valid & req_write;
  assign rd_evt    = req_valid & ~req_write;
  assign byte_off  = req_addr[OFF_W-1:0];
  assign mem_addr  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign align_err = req_valid & ~req_byte & (|byte_off);
  assign big_mode  = (mode == ENDIAN_BIG);

  mlu_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .strap_big(strap_big), .mode(mode)
  );

  mlu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .mode(mode), .wr_en(wr_evt), .is_byte(req_byte), .offset(byte_off),
    .wdata(req_wdata), .we(mem_we), .wdata_out(mem_wdata), .lane_sel(lane_sel)
  );

  mlu_load_path #(.DATA_W(DATA_W)) u_load (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_evt), .is_byte(req_byte),
    .lane_sel(lane_sel), .rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  mlu_fetch_seq #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst_n(rst_n), .adv(fetch_adv), .branch(fetch_branch),
    .target(fetch_target), .pc(fetch_pc)
  );
endmodule

// File: rtl/mlu_checker.sv
module mlu_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_byte,
  input logic [LANES-1:0]  mem_we,
  input logic              align_err,
  input logic              ld_valid,
  input logic              big_mode,
  input logic              wr_evt,
  input logic              rd_evt,
  input logic              fetch_adv,
  input logic              fetch_branch,
  input logic [ADDR_W-1:0] fetch_target,
  input logic [ADDR_W-1:0] fetch_pc
);
  assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(big_mode));

  assert_word_store_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !req_byte) |-> (mem_we == {LANES{1'b1}}));

  assert_byte_store_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && req_byte) |-> ($countones(mem_we) == 1));

  assert_no_stray_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |-> (mem_we == '0));

  assert_load_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> ld_valid);

  assert_load_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> !ld_valid);

  assert_byte_no_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_byte) |-> !align_err);

  assert_branch_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_branch |=> (fetch_pc == $past(fetch_target)));

  assert_seq_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_adv && !fetch_branch) |=> (fetch_pc == $past(fetch_pc) + ADDR_W'(4)));

  assert_seq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_adv && !fetch_branch) |=> $stable(fetch_pc));
endmodule

bind mem_lane_unit mlu_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mlu_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_byte(req_byte), .mem_we(mem_we), .align_err(align_err),
  .ld_valid(ld_valid), .big_mode(big_mode), .wr_evt(wr_evt), .rd_evt(rd_evt),
  .fetch_adv(fetch_adv), .fetch_branch(fetch_branch),
  .fetch_target(fetch_target), .fetch_pc(fetch_pc)
);

// File: tb/test_mem_lane_unit.sv
module test_mem_lane_unit;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_big = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic [31:0] mem_addr, mem_wdata, ld_data, fetch_pc;
  logic [3:0]  mem_we;
  logic        ld_valid, align_err, big_mode;
  logic        fetch_adv = 1'b0, fetch_branch = 1'b0;
  logic [31:0] fetch_target = '0;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_lane_unit i_mem_lane_unit (
    .clk(clk), .rst_n(rst_n), .strap_big(strap_big),
    .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .align_err(align_err),
    .big_mode(big_mode), .fetch_adv(fetch_adv), .fetch_branch(fetch_branch),
    .fetch_target(fetch_target), .fetch_pc(fetch_pc)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
    fetch_adv = 1'b0; fetch_branch = 1'b0;
  endtask

  // R1, R9, R10: reset with a given strap, then show the strap is ignored.
  task automatic t_reset(input bit big);
    @(negedge clk);
    rst_n = 1'b0; strap_big = big; go_idle();
    repeat (2) @(negedge clk);
    chk({31'd0, ld_valid}, 32'd0, "R10 ld_valid in reset");
    chk(fetch_pc, RST_PC, "R9 reset pc");
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'd0, big_mode}, {31'd0, big}, "R1 mode latched");
    strap_big = ~big;
    repeat (3) @(negedge clk);
    chk({31'd0, big_mode}, {31'd0, big}, "R1 strap ignored after reset");
  endtask

  // R2, R4, R5, R8: byte stores at every offset.
  task automatic t_byte_stores(input bit big);
    for (int off = 0; off < 4; off++) begin
      logic [7:0] b;
      logic [3:0] exp_we;
      @(negedge clk);
      b = 8'h3C + 8'(off * 17);
      exp_we = big ? (4'b1000 >> off) : (4'b0001 << off);
      req_valid = 1'b1; req_write = 1'b1; req_byte = 1'b1;
      req_addr = 32'h0000_2010 + 32'(off);
      req_wdata = {24'hDEAD_BE, b};
      #2;
      chk({28'd0, mem_we}, {28'd0, exp_we}, "R4 byte lane enable");
      chk(mem_wdata, {b, b, b, b}, "R4 byte replicated");
      chk(mem_addr, 32'h0000_2010, "R2 aligned address byte");
      chk({31'd0, align_err}, 32'd0, "R8 no error on byte");
    end
    @(negedge clk);
    go_idle();
    #2;
    chk({28'd0, mem_we}, 32'd0, "R5 no strobe when idle");
    req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b1;
    #2;
    chk({28'd0, mem_we}, 32'd0, "R5 no strobe on load");
    go_idle();
  endtask

  // R2, R3, R8: word stores, aligned and misaligned.
  task automatic t_word_stores();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_byte = 1'b0;
    req_addr = 32'h0000_0040; req_wdata = 32'h1234_5678;
    #2;
    chk({28'd0, mem_we}, 32'h0000_000F, "R3 word strobes");
    chk(mem_wdata, 32'h1234_5678, "R3 word data");
    chk({31'd0, align_err}, 32'd0, "R8 aligned word");
    @(negedge clk);
    req_addr = 32'h0000_0043;
    #2;
    chk({31'd0, align_err}, 32'd1, "R8 misaligned word flag");
    chk(mem_addr, 32'h0000_0040, "R2 misaligned forced aligned");
    chk({28'd0, mem_we}, 32'h0000_000F, "R3 misaligned still writes");
    @(negedge clk);
    req_write = 1'b0; req_addr = 32'h0000_0082;
    #2;
    chk({31'd0, align_err}, 32'd1, "R8 misaligned word load flag");
    @(negedge clk);
    go_idle();
  endtask

  // R6, R7: byte loads at every offset and a word load.
  task automatic t_loads(input bit big);
    logic [31:0] w;
    w = 32'h8899_AABB;
    for (int off = 0; off < 4; off++) begin
      int lane;
      @(negedge clk);
      lane = big ? (3 - off) : off;
      req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b1;
      req_addr = 32'h0000_3000 + 32'(off); mem_rdata = w;
      @(posedge clk); #1;
      chk({31'd0, ld_valid}, 32'd1, "R6 byte load valid");
      chk(ld_data, (w >> (8 * lane)) & 32'hFF, "R6 byte load value");
    end
    @(negedge clk);
    go_idle(); mem_rdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    chk({31'd0, ld_valid}, 32'd0, "R6 no load no valid");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b0;
    req_addr = 32'h0000_3004; mem_rdata = 32'hC0FF_EE01;
    @(posedge clk); #1;
    chk(ld_data, 32'hC0FF_EE01, "R7 word load unchanged");
    @(negedge clk);
    go_idle();
  endtask

  // R9: sequential fetch, hold, branch priority, wraparound.
  task automatic t_fetch();
    @(negedge clk);
    fetch_adv = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(posedge clk); #1;
      chk(fetch_pc, RST_PC + 32'(4 * i), "R9 sequential step");
    end
    @(negedge clk);
    fetch_adv = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk(fetch_pc, RST_PC + 32'd12, "R9 hold");
    @(negedge clk);
    fetch_adv = 1'b1; fetch_branch = 1'b1; fetch_target = 32'hFFFF_FFFC;
    @(posedge clk); #1;
    chk(fetch_pc, 32'hFFFF_FFFC, "R9 branch priority");
    @(negedge clk);
    fetch_branch = 1'b0;
    @(posedge clk); #1;
    chk(fetch_pc, 32'h0000_0000, "R9 wraparound");
    @(negedge clk);
    go_idle();
  endtask

  initial begin
    t_reset(1'b0);
    t_byte_stores(1'b0);
    t_word_stores();
    t_loads(1'b0);
    t_fetch();
    t_reset(1'b1);
    t_byte_stores(1'b1);
    t_loads(1'b1);
    t_word_stores();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule